// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Channel

This block is a single DMA channel that follows a chain of fixed-size, 8-byte descriptors held in system memory. It moves 32-bit words between a streaming device port and memory buffers named by those descriptors. A build-time parameter fixes the direction: memory to device (transmit) or device to memory (receive). Software programs the channel through a four-entry write-only register port. One simple 32-bit memory request port carries both the descriptor fetches and the data traffic.

When the descriptor marked as last has been fully moved, the channel emits a one-cycle completion pulse. That pulse is meant to set the channel's bit in an external write-one-to-clear interrupt status register. A descriptor that is not marked valid, or whose length is not a whole number of words, halts the channel with an error flag. In the receive direction the channel also counts written bytes against a programmable row size and pulses at each row boundary. Writing zero to the receive enable aborts a walk at once.

Top module: `sgdma_chan`

## Requirements
- R1: A descriptor is two words at pointer P, fetched in the order P then P+4. Word P holds flags in bits [7:0], a reserved byte in [15:8] and the length in bytes in [31:16]. Word P+4 holds the 32-bit buffer address. Flag bit 0 means valid, bit 1 means last and bit 5 means transfer.
- R2: In the transmit build, a register write with select 1 (descriptor address low) while idle starts the walk at the written address, and busy is high from the next cycle. A write with select 0 (descriptor address high) never starts anything.
- R3: In the receive build, a select 1 write only stores the list address. The walk starts on a select 2 (enable) write with bit 0 set while idle, and the stored address is used.
- R4: The transmit build reads the buffer words at ascending addresses in steps of 4 and presents them on the device output in that order, length/4 words per descriptor. The output holds its word while ready is low.
- R5: The receive build accepts length/4 words from the device input and writes them to the buffer at ascending addresses in steps of 4, in arrival order.
- R6: After a descriptor without the last flag has been consumed, the next descriptor is fetched at P+8.
- R7: After the final word of the last descriptor has been handed over, done pulses for exactly one cycle and busy is low in that same cycle. In the transmit build the final hand-over is the device output handshake. In the receive build it is the memory write acceptance.
- R8: A fetched descriptor with the valid bit clear halts the channel. Busy goes low and err goes high, with no data moved and no done pulse. Err stays high until the next start, which clears it.
- R9: A valid descriptor whose length has either of bits [1:0] set halts the channel with err high, no data moved and no done pulse.
- R10: A valid descriptor with the transfer flag clear or with zero length moves no data. The walk then goes on: to the next descriptor, or to completion if it is the last.
- R11: A start write that arrives while busy is ignored, and the walk in progress finishes its original list.
- R12: In the receive build, select 3 sets the row size in bytes. Each accepted memory write adds 4 to a row count that restarts at every start. When the count reaches the row size, row_end pulses for one cycle and the count wraps to zero. A row size of zero gives no pulses.
- R13: In the receive build, a select 2 write with bit 0 clear while busy stops the channel in the next cycle. After that no memory request is issued, no device word is accepted and no done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address high, 1 address low, 2 enable, 3 row size |
| reg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| dev_in_valid | input | 1 | Device input word valid (receive build) |
| dev_in_ready | output | 1 | Channel can take a device word |
| dev_in_data | input | 32 | Device input word |
| dev_out_valid | output | 1 | Device output word valid (transmit build) |
| dev_out_ready | input | 1 | Device takes the output word |
| dev_out_data | output | 32 | Device output word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Descriptor error flag |
| row_end | output | 1 | One-cycle row boundary pulse (receive build) |

## Verification
In the receive build the last memory write of a list can close a row and finish the walk at the same clock edge. Done and row_end then rise together. The bench sets up this case by using 8-byte rows with 8-byte descriptors, under random stalls on both the memory and device handshakes. It then checks that the done count and the row count each match the expected totals, so a pulse lost through the collision is caught. A start write is also sent while a transmit walk is still running, and the bench checks that the original list completes with no error and no stray fetch.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
    localparam int SG_AW         = 32;
    localparam int SG_DW         = 32;
    localparam int SG_LW         = 16;
    localparam int SG_DESC_BYTES = 8;
    localparam int SG_WORD_BYTES = 4;
    localparam int FLG_VALID     = 0;
    localparam int FLG_LAST      = 1;
    localparam int FLG_XFER      = 5;
    localparam int LEN_LSB       = 16;

    typedef enum logic [3:0] {
        ST_IDLE, ST_D0_REQ, ST_D0_WAIT, ST_D1_REQ, ST_D1_WAIT,
        ST_RD_REQ, ST_RD_WAIT, ST_DEV_OUT, ST_DEV_IN, ST_WR_REQ
    } sg_state_e;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             xfer;
        logic [SG_LW-1:0] len;
        logic             len_ok;
    } sg_desc_t;

    typedef struct packed {
        sg_state_e        st;
        logic [SG_AW-1:0] list;
        logic [SG_AW-1:0] ptr;
        logic [SG_AW-1:0] addr;
        logic [SG_LW-1:0] remain;
        logic             last;
        logic             xfer;
        logic [SG_DW-1:0] word;
        logic             err;
        logic             done;
        logic [SG_LW-1:0] row_bytes;
    } sg_regs_t;
endpackage

// File: rtl/sgdma_desc_dec.sv
module sgdma_desc_dec
    import sgdma_pkg::*;
(
    input  logic [2:0]       flag_bits,   // {xfer, last, valid}
    input  logic [SG_LW-1:0] len_field,
    output sg_desc_t         desc
);
    localparam int ALIGN_BITS = $clog2(SG_WORD_BYTES);

    always_comb begin
        desc.valid  = flag_bits[0];
        desc.last   = flag_bits[1];
        desc.xfer   = flag_bits[2];
        desc.len    = len_field;
        desc.len_ok = (len_field[ALIGN_BITS-1:0] == '0);
    end
endmodule

// File: rtl/sgdma_row_count.sv
module sgdma_row_count
    import sgdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [SG_LW-1:0] row_bytes,
    output logic             row_end
);
    typedef struct packed {
        logic [SG_LW-1:0] cnt;
        logic             pulse;
    } rc_t;

    rc_t              rc_d, rc_q;
    logic [SG_LW-1:0] cnt_next;

    always_comb begin
        rc_d       = rc_q;
        rc_d.pulse = 1'b0;
        cnt_next   = rc_q.cnt + SG_LW'(SG_WORD_BYTES);
        if (clear) begin
            rc_d.cnt = '0;
        end else if (step) begin
            if (row_bytes != '0 && cnt_next >= row_bytes) begin
                rc_d.cnt   = '0;
                rc_d.pulse = 1'b1;
            end else begin
                rc_d.cnt = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= '0;
        else        rc_q <= rc_d;
    end

    assign row_end = rc_q.pulse;
endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
    import sgdma_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [SG_DW-1:0] reg_wdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [SG_AW-1:0] mem_req_addr,
    output logic [SG_DW-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [SG_DW-1:0] mem_rsp_data,
    input  logic             dev_in_valid,
    output logic             dev_in_ready,
    input  logic [SG_DW-1:0] dev_in_data,
    output logic             dev_out_valid,
    input  logic             dev_out_ready,
    output logic [SG_DW-1:0] dev_out_data,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             row_end
);
    localparam logic [1:0] SEL_LO  = 2'd1;
    localparam logic [1:0] SEL_EN  = 2'd2;
    localparam logic [1:0] SEL_ROW = 2'd3;

    sg_regs_t  q, d;
    sg_desc_t  dsc;
    logic      idle, start, abort, word_done, desc_end;
    sg_state_e data_st;

    sgdma_desc_dec u_dec (
        .flag_bits ({mem_rsp_data[FLG_XFER], mem_rsp_data[FLG_LAST], mem_rsp_data[FLG_VALID]}),
        .len_field (mem_rsp_data[LEN_LSB +: SG_LW]),
        .desc      (dsc)
    );

    assign idle    = (q.st == ST_IDLE);
    assign data_st = IS_RX ? ST_DEV_IN : ST_RD_REQ;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        word_done = 1'b0;
        desc_end  = 1'b0;
        start     = 1'b0;
        abort     = 1'b0;

        if (reg_wr && reg_sel == SEL_LO && idle) d.list = reg_wdata;
        if (IS_RX) begin
            if (reg_wr && reg_sel == SEL_ROW) d.row_bytes = reg_wdata[SG_LW-1:0];
            if (reg_wr && reg_sel == SEL_EN) begin
                if (!reg_wdata[0]) abort = !idle;
                else               start = idle;
            end
        end else begin
            start = reg_wr && reg_sel == SEL_LO && idle;
        end

        case (q.st)
            ST_D0_REQ:  if (mem_req_ready) d.st = ST_D0_WAIT;
            ST_D0_WAIT: if (mem_rsp_valid) begin
                d.last   = dsc.last;
                d.xfer   = dsc.xfer;
                d.remain = dsc.len;
                if (!dsc.valid || !dsc.len_ok) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.st = ST_D1_REQ;
                end
            end
            ST_D1_REQ:  if (mem_req_ready) d.st = ST_D1_WAIT;
            ST_D1_WAIT: if (mem_rsp_valid) begin
                d.addr = mem_rsp_data;
                if (q.xfer && q.remain != '0) d.st = data_st;
                else                          desc_end = 1'b1;
            end
            ST_RD_REQ:  if (mem_req_ready) d.st = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) begin
                d.word = mem_rsp_data;
                d.st   = ST_DEV_OUT;
            end
            ST_DEV_OUT: word_done = dev_out_ready;
            ST_DEV_IN:  if (dev_in_valid) begin
                d.word = dev_in_data;
                d.st   = ST_WR_REQ;
            end
            ST_WR_REQ:  word_done = mem_req_ready;
            default:    ;
        endcase

        if (word_done) begin
            d.addr   = q.addr + SG_AW'(SG_WORD_BYTES);
            d.remain = q.remain - SG_LW'(SG_WORD_BYTES);
            if (q.remain == SG_LW'(SG_WORD_BYTES)) desc_end = 1'b1;
            else                                   d.st = data_st;
        end

        if (desc_end) begin
            if (q.last) begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end else begin
                d.ptr = q.ptr + SG_AW'(SG_DESC_BYTES);
                d.st  = ST_D0_REQ;
            end
        end

        if (start) begin
            d.st  = ST_D0_REQ;
            d.ptr = IS_RX ? q.list : reg_wdata;
            d.err = 1'b0;
        end
        if (abort) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        if (IS_RX) begin : g_rows
            sgdma_row_count u_rows (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (start),
                .step      (q.st == ST_WR_REQ && mem_req_ready),
                .row_bytes (q.row_bytes),
                .row_end   (row_end)
            );
        end else begin : g_no_rows
            assign row_end = 1'b0;
        end
    endgenerate

    always_comb begin
        case (q.st)
            ST_D0_REQ: mem_req_addr = q.ptr;
            ST_D1_REQ: mem_req_addr = q.ptr + SG_AW'(SG_WORD_BYTES);
            default:   mem_req_addr = q.addr;
        endcase
    end

    assign mem_req_valid = (q.st == ST_D0_REQ) || (q.st == ST_D1_REQ) ||
                           (q.st == ST_RD_REQ) || (q.st == ST_WR_REQ);
    assign mem_req_write = (q.st == ST_WR_REQ);
    assign mem_req_wdata = q.word;
    assign dev_out_valid = (q.st == ST_DEV_OUT);
    assign dev_out_data  = q.word;
    assign dev_in_ready  = (q.st == ST_DEV_IN);
    assign busy          = !idle;
    assign done          = q.done;
    assign err           = q.err;
endmodule

// File: rtl/sgdma_chan_chk.sv
module sgdma_chan_chk
    import sgdma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [SG_AW-1:0] mem_req_addr,
    input logic             dev_out_valid,
    input logic             dev_out_ready,
    input logic [SG_DW-1:0] dev_out_data,
    input logic             dev_in_ready,
    input logic             row_end
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> ((mem_req_valid && $stable(mem_req_addr)) || !busy)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data))); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !dev_out_valid && !dev_in_ready)); // R13
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!done && !busy)); // R8
    AST_ROW_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |-> $past(mem_req_valid && mem_req_ready && mem_req_write)); // R12
endmodule

bind sgdma_chan sgdma_chan_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_ready  (dev_in_ready),
    .row_end       (row_end)
);

// File: tb/test_sgdma_chan.sv
`timescale 1ns/1ps
module test_sgdma_chan;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // transmit instance signals
    logic        t_reg_wr = 0;  logic [1:0] t_reg_sel = 0;  logic [31:0] t_reg_wdata = 0;
    logic        t_req_valid, t_req_write;  logic t_mem_ready = 0;
    logic [31:0] t_req_addr, t_req_wdata;
    logic        t_rsp_valid = 0;  logic [31:0] t_rsp_data = 0;
    logic        t_in_ready, t_out_valid;  logic t_out_ready = 0;  logic [31:0] t_out_data;
    logic        t_busy, t_done, t_err, t_row_end;
    // receive instance signals
    logic        r_reg_wr = 0;  logic [1:0] r_reg_sel = 0;  logic [31:0] r_reg_wdata = 0;
    logic        r_req_valid, r_req_write;  logic r_mem_ready = 0;
    logic [31:0] r_req_addr, r_req_wdata;
    logic        r_rsp_valid = 0;  logic [31:0] r_rsp_data = 0;
    logic        r_in_ready;  logic r_in_valid = 0;  logic [31:0] r_in_data = 0;
    logic        r_out_valid;  logic [31:0] r_out_data;
    logic        r_busy, r_done, r_err, r_row_end;

    sgdma_chan #(.IS_RX(1'b0)) i_sgdma_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(t_reg_wr), .reg_sel(t_reg_sel), .reg_wdata(t_reg_wdata),
        .mem_req_valid(t_req_valid), .mem_req_ready(t_mem_ready), .mem_req_write(t_req_write),
        .mem_req_addr(t_req_addr), .mem_req_wdata(t_req_wdata),
        .mem_rsp_valid(t_rsp_valid), .mem_rsp_data(t_rsp_data),
        .dev_in_valid(1'b0), .dev_in_ready(t_in_ready), .dev_in_data(32'h0),
        .dev_out_valid(t_out_valid), .dev_out_ready(t_out_ready), .dev_out_data(t_out_data),
        .busy(t_busy), .done(t_done), .err(t_err), .row_end(t_row_end));

    sgdma_chan #(.IS_RX(1'b1)) i_sgdma_chan_rx (
        .clk(clk), .rst_n(rst_n), .reg_wr(r_reg_wr), .reg_sel(r_reg_sel), .reg_wdata(r_reg_wdata),
        .mem_req_valid(r_req_valid), .mem_req_ready(r_mem_ready), .mem_req_write(r_req_write),
        .mem_req_addr(r_req_addr), .mem_req_wdata(r_req_wdata),
        .mem_rsp_valid(r_rsp_valid), .mem_rsp_data(r_rsp_data),
        .dev_in_valid(r_in_valid), .dev_in_ready(r_in_ready), .dev_in_data(r_in_data),
        .dev_out_valid(r_out_valid), .dev_out_ready(1'b0), .dev_out_data(r_out_data),
        .busy(r_busy), .done(r_done), .err(r_err), .row_end(r_row_end));

    logic [31:0] memt [0:255];
    logic [31:0] memr [0:255];
    logic [31:0] tx_exp [$];
    logic [63:0] rx_exp [$];
    logic [31:0] rx_src [$];
    int   n_cmp = 0, n_bad = 0, cyc = 0;
    int   t_done_n = 0, t_out_n = 0, r_done_n = 0, r_row_n = 0, r_wr_n = 0;
    bit   t_pend = 0, r_pend = 0, rx_feed = 0, over = 0;
    logic [7:0]  t_pidx = 0, r_pidx = 0;
    logic [15:0] lf = 16'hACE1;

    function automatic void check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    function automatic void summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endfunction

    // scoreboard monitor and memory / device responders, all at the falling edge
    always @(negedge clk) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc++;
        if (rst_n) begin
            t_rsp_valid = 1'b0;
            if (t_pend) begin t_rsp_valid = 1'b1; t_rsp_data = memt[t_pidx]; t_pend = 0; end
            t_mem_ready = lf[0] | lf[5];
            if (t_req_valid && t_mem_ready) begin
                if (t_req_write) memt[t_req_addr[9:2]] = t_req_wdata;
                else begin t_pend = 1; t_pidx = t_req_addr[9:2]; end
            end
            t_out_ready = lf[1] | lf[7];
            if (t_out_valid && t_out_ready) begin
                t_out_n++;
                if (tx_exp.size() == 0) check(1'b0, "R4 unexpected device word", t_out_data, 0);
                else begin
                    logic [31:0] e;
                    e = tx_exp.pop_front();
                    check(t_out_data == e, "R4 device word order", t_out_data, e);
                end
            end
            if (t_done) begin
                t_done_n++;
                check(!t_busy, "R7 busy low with done", t_busy, 0);
            end

            r_rsp_valid = 1'b0;
            if (r_pend) begin r_rsp_valid = 1'b1; r_rsp_data = memr[r_pidx]; r_pend = 0; end
            r_mem_ready = lf[2] | lf[8];
            if (r_req_valid && r_mem_ready) begin
                if (r_req_write) begin
                    r_wr_n++;
                    memr[r_req_addr[9:2]] = r_req_wdata;
                    if (rx_exp.size() == 0) check(1'b0, "R5 unexpected memory write", {r_req_addr, r_req_wdata}, 0);
                    else begin
                        logic [63:0] e;
                        e = rx_exp.pop_front();
                        check({r_req_addr, r_req_wdata} == e, "R5 memory write", {r_req_addr, r_req_wdata}, e);
                    end
                end else begin
                    r_pend = 1; r_pidx = r_req_addr[9:2];
                end
            end
            r_in_valid = rx_feed && rx_src.size() != 0 && (lf[3] | lf[9]);
            r_in_data  = r_in_valid ? rx_src[0] : 32'h0;
            if (r_in_valid && r_in_ready) void'(rx_src.pop_front());
            if (r_done) r_done_n++;
            if (r_row_end) r_row_n++;
        end
        if (cyc > 100000 && !over) begin
            over = 1;
            check(1'b0, "watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic wr_reg(input bit rx, input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        if (rx) begin r_reg_wr = 1; r_reg_sel = sel; r_reg_wdata = v; end
        else    begin t_reg_wr = 1; t_reg_sel = sel; t_reg_wdata = v; end
        @(negedge clk);
        r_reg_wr = 0; t_reg_wr = 0;
    endtask

    task automatic wait_idle(input bit rx, input string req);
        int n = 0;
        while ((rx ? r_busy : t_busy) && n < 5000) begin @(negedge clk); n++; end
        check(n < 5000, req, n, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin memt[i] = 32'h0; memr[i] = 32'h0; end
        // transmit list at 0x000 (R1, R6, R10)
        memt[0] = {16'd8,  8'h00, 8'h21}; memt[1] = 32'h100;
        memt[2] = {16'd0,  8'h00, 8'h21}; memt[3] = 32'h140;
        memt[4] = {16'd8,  8'h00, 8'h01}; memt[5] = 32'h180;
        memt[6] = {16'd12, 8'h00, 8'h23}; memt[7] = 32'h200;
        memt[64] = 32'hA000_0001; memt[65] = 32'hA000_0002;
        memt[80] = 32'hDEAD_0000; memt[96] = 32'hDEAD_0001; memt[97] = 32'hDEAD_0002;
        memt[128] = 32'hB000_0001; memt[129] = 32'hB000_0002; memt[130] = 32'hB000_0003;
        memt[192] = {16'd8, 8'h00, 8'h20}; memt[193] = 32'h100;  // valid clear
        memt[208] = {16'd6, 8'h00, 8'h23}; memt[209] = 32'h100;  // length 6
        memt[224] = {16'd8, 8'h00, 8'h03}; memt[225] = 32'h100;  // last, no transfer
        // receive lists
        memr[0]  = {16'd8,  8'h00, 8'h21}; memr[1]  = 32'h100;
        memr[2]  = {16'd8,  8'h00, 8'h23}; memr[3]  = 32'h180;
        memr[16] = {16'd64, 8'h00, 8'h23}; memr[17] = 32'h200;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!t_busy && !r_busy, "R2 busy low after reset", {t_busy, r_busy}, 0);
        check(!t_done && !t_err && !r_done && !r_err, "R7 done and err low after reset", {t_done, t_err, r_done, r_err}, 0);
        check(!t_req_valid && !t_out_valid && !r_in_ready, "R13 quiet after reset", {t_req_valid, t_out_valid, r_in_ready}, 0);

        // R2: the high address register does not start anything
        wr_reg(0, 2'd0, 32'h55);
        repeat (4) @(negedge clk);
        check(!t_busy && !t_req_valid, "R2 high address write ignored", t_busy, 0);

        // R2, R4, R6, R10, R11: main transmit walk
        tx_exp.push_back(32'hA000_0001); tx_exp.push_back(32'hA000_0002);
        tx_exp.push_back(32'hB000_0001); tx_exp.push_back(32'hB000_0002); tx_exp.push_back(32'hB000_0003);
        wr_reg(0, 2'd1, 32'h0);
        check(t_busy, "R2 busy after low address write", t_busy, 1);
        wr_reg(0, 2'd1, 32'h300);  // R11: start while busy
        wait_idle(0, "R7 transmit walk completes");
        repeat (3) @(negedge clk);
        check(tx_exp.size() == 0, "R4 all transmit words seen", tx_exp.size(), 0);
        check(t_out_n == 5, "R10 skipped descriptors moved no data", t_out_n, 5);
        check(t_done_n == 1, "R7 one completion pulse", t_done_n, 1);
        check(!t_err, "R11 restart while busy ignored", t_err, 0);

        // R8: invalid descriptor
        wr_reg(0, 2'd1, 32'h300);
        wait_idle(0, "R8 halt on invalid descriptor");
        repeat (10) @(negedge clk);
        check(t_err, "R8 err raised and held", t_err, 1);
        check(t_out_n == 5 && t_done_n == 1, "R8 no data and no done", {t_out_n, t_done_n}, {32'd5, 32'd1});

        // R9: misaligned length, start clears err first (R8)
        wr_reg(0, 2'd1, 32'h340);
        check(!t_err && t_busy, "R8 err cleared at start", {t_err, t_busy}, 1);
        wait_idle(0, "R9 halt on misaligned length");
        @(negedge clk);
        check(t_err, "R9 err on misaligned length", t_err, 1);
        check(t_out_n == 5 && t_done_n == 1, "R9 no data and no done", {t_out_n, t_done_n}, {32'd5, 32'd1});

        // R10: last descriptor without transfer flag completes
        wr_reg(0, 2'd1, 32'h380);
        wait_idle(0, "R10 walk over no-transfer descriptor");
        @(negedge clk);
        check(t_done_n == 2 && !t_err && t_out_n == 5, "R10 completes with no data", {t_done_n, t_out_n}, {32'd2, 32'd5});

        // receive: R3, R5, R6, R12, R7
        wr_reg(1, 2'd3, 32'd8);
        rx_src.push_back(32'hC000_0000); rx_src.push_back(32'hC000_0001);
        rx_src.push_back(32'hC000_0002); rx_src.push_back(32'hC000_0003);
        rx_exp.push_back({32'h100, 32'hC000_0000}); rx_exp.push_back({32'h104, 32'hC000_0001});
        rx_exp.push_back({32'h180, 32'hC000_0002}); rx_exp.push_back({32'h184, 32'hC000_0003});
        rx_feed = 1;
        wr_reg(1, 2'd1, 32'h0);
        repeat (5) @(negedge clk);
        check(!r_busy && r_wr_n == 0, "R3 address write alone does not start", r_busy, 0);
        wr_reg(1, 2'd2, 32'h1);
        check(r_busy, "R3 enable starts receive walk", r_busy, 1);
        wait_idle(1, "R7 receive walk completes");
        repeat (3) @(negedge clk);
        check(rx_exp.size() == 0 && r_wr_n == 4, "R5 four writes", r_wr_n, 4);
        check(memr[64] == 32'hC000_0000 && memr[97] == 32'hC000_0003, "R6 second buffer via next descriptor", memr[97], 32'hC000_0003);
        check(r_done_n == 1, "R7 receive completion pulse", r_done_n, 1);
        check(r_row_n == 2, "R12 row boundaries", r_row_n, 2);

        // R13: abort a long receive walk
        rx_src.push_back(32'hD000_0000); rx_src.push_back(32'hD000_0001);
        rx_exp.push_back({32'h200, 32'hD000_0000}); rx_exp.push_back({32'h204, 32'hD000_0001});
        wr_reg(1, 2'd1, 32'h40);
        wr_reg(1, 2'd2, 32'h1);
        begin
            int n = 0;
            while (r_wr_n < 6 && n < 2000) begin @(negedge clk); n++; end
        end
        repeat (4) @(negedge clk);
        check(r_busy, "R13 walk still waiting for device data", r_busy, 1);
        wr_reg(1, 2'd2, 32'h0);
        check(!r_busy, "R13 abort stops channel", r_busy, 0);
        rx_src.push_back(32'hD000_0002);
        repeat (20) @(negedge clk);
        check(r_wr_n == 6 && r_done_n == 1, "R13 no writes or done after abort", {r_wr_n, r_done_n}, {32'd6, 32'd1});
        check(rx_src.size() == 1, "R13 no device word taken after abort", rx_src.size(), 1);

        over = 1;
        summary();
        $finish;
    end
endmodule